// File: doc/BRIEF.md
# Master-Mode Audio Frame Clock Generator

This block sits in the master clock domain of an audio serial port that runs as clock master. From the master clock it derives the bit-clock timing and the left/right frame clock. The master-clock-to-frame ratio comes from a table indexed by a two-bit speed mode and a two-bit divider select. The table mixes power-of-two ratios with 1.5× ratios. A frame always holds 64 bit periods, so the number of master clocks per bit can be fractional. A fractional accumulator spreads those bit periods evenly, so every frame lasts exactly the selected ratio.

The bit clock leaves the block as a one-cycle clock-enable strobe. It marks the falling edge at which a new bit period begins. A second strobe marks the first bit of each frame. The frame clock leaves the block as a registered level. The speed mode and divider select are captured only while reset is held. Pin changes made after reset release have no effect until the next reset.

Top module: `fclk_gen`

## Requirements
- R1: With speed mode 00 (single speed), divider select 00, 01, 10 and 11 give 256, 384, 512 and 1024 master clocks per frame.
- R2: With speed mode 01 (double speed), divider select 00, 01, 10 and 11 give 128, 192, 256 and 512 master clocks per frame.
- R3: With speed mode 10 or 11 (quad speed), divider select 00, 01, 10 and 11 give 64, 96, 128 and 256 master clocks per frame.
- R4: Every frame holds exactly 64 `bit_tick` pulses, whatever the ratio, including the 1.5× ratios.
- R5: `lrclk` is low for the first 32 bit periods of a frame and high for the last 32. It changes only in a cycle where `bit_tick` is high. `frame_start` pulses together with the `bit_tick` that opens each frame.
- R6: `speed_mode` and `div_sel` are sampled only while `rst` is high. Changes to them after release do not alter the outputs.
- R7: While `rst` is high, `bit_tick`, `frame_start` and `lrclk` are low in the cycle after each reset edge.
- R8: Counting master clock edges after release from t = 1, `bit_tick` is high after edge t exactly when floor(64·t/N) differs from floor(64·(t−1)/N), where N is the selected ratio. The first frame therefore starts with `lrclk` low at the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset; configuration is loaded while high |
| speed_mode | input | 2 | Speed mode: 00 single, 01 double, 10/11 quad |
| div_sel | input | 2 | Divider select; a pin tied low reads 0 and tied high reads 1 |
| bit_tick | output | 1 | One-cycle strobe at each bit-clock falling edge |
| frame_start | output | 1 | One-cycle strobe on the first bit of each frame |
| lrclk | output | 1 | Registered frame clock level at the sample rate |

## Verification
The bench builds the block with its default parameters: 64 bit periods per frame and a single-speed base ratio of 256. With these values the full table of twelve ratios is reachable, from a bit strobe on every master clock (ratio 64) up to a 1024-cycle frame. Each ratio runs for two full frames. The 1.5× ratios exercise the accumulator's uneven 1/2-cycle bit spacing and the wrap from a 96-cycle frame back into the next one. The reserved quad code and pin changes made after release are covered by separate runs.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_QUAD_X = 2'b11
    } speed_e;

    typedef struct packed {
        speed_e     speed;
        logic [1:0] dsel;
    } cfg_t;

    // Master clocks per frame for a configuration, given the single-speed base.
    function automatic int unsigned frame_ratio(cfg_t c, int unsigned base);
        int unsigned b;
        int unsigned r;
        case (c.speed)
            SPD_SINGLE: b = base;
            SPD_DOUBLE: b = base >> 1;
            default:    b = base >> 2;
        endcase
        case (c.dsel)
            2'b00:   r = b;
            2'b01:   r = b + (b >> 1);
            2'b10:   r = b << 1;
            default: r = b << 2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fclk_cfg_latch.sv
module fclk_cfg_latch
    import fclk_pkg::*;
#(
    parameter int unsigned SINGLE_BASE = 256,
    parameter int unsigned RATIO_W     = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  cfg_t               cfg_in,
    output logic [RATIO_W-1:0] ratio_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= RATIO_W'(frame_ratio(cfg_in, SINGLE_BASE));
        end
    end

    // Ratio stays frozen once reset is released.
    p_ratio_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(ratio_q));

endmodule

// File: rtl/fclk_frac_div.sv
module fclk_frac_div #(
    parameter int unsigned STEP  = 64,
    parameter int unsigned ACC_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] ratio,
    output logic             tick_d,
    output logic             tick_q
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum = {1'b0, acc_q} + (ACC_W+1)'(STEP);
        if (sum >= {1'b0, ratio}) begin
            tick_d = 1'b1;
            acc_d  = ACC_W'(sum - {1'b0, ratio});
        end else begin
            tick_d = 1'b0;
            acc_d  = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= tick_d;
        end
    end

    // Residue stays below the frame ratio, so no frame gains a bit (R4).
    p_acc_below_ratio_r4: assert property (@(posedge clk) disable iff (rst)
        acc_q < ratio);

    p_tick_quiet_r7: assert property (@(posedge clk)
        rst |=> !tick_q);

endmodule

// File: rtl/fclk_frame_seq.sv
module fclk_frame_seq #(
    parameter int unsigned BITS_PER_FRAME = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_d,
    output logic lrclk,
    output logic frame_start
);

    localparam int unsigned BIT_W = $clog2(BITS_PER_FRAME);

    logic [BIT_W-1:0] slot_q;
    logic [BIT_W-1:0] slot_nxt;

    assign slot_nxt = slot_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q      <= '1;
            lrclk       <= 1'b0;
            frame_start <= 1'b0;
        end else if (tick_d) begin
            slot_q      <= slot_nxt;
            lrclk       <= slot_nxt[BIT_W-1];
            frame_start <= (slot_nxt == '0);
        end else begin
            frame_start <= 1'b0;
        end
    end

    p_frame_opens_low_r5: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !lrclk);

    p_seq_quiet_r7: assert property (@(posedge clk)
        rst |=> (!lrclk && !frame_start));

endmodule

// File: rtl/fclk_gen.sv
module fclk_gen
    import fclk_pkg::*;
#(
    parameter int unsigned BITS_PER_FRAME = 64,
    parameter int unsigned SINGLE_BASE    = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_mode,
    input  logic [1:0] div_sel,
    output logic       bit_tick,
    output logic       frame_start,
    output logic       lrclk
);

    localparam int unsigned RATIO_W = $clog2(SINGLE_BASE * 4 + 1);

    cfg_t               cfg_pins;
    logic [RATIO_W-1:0] ratio;
    logic               tick_d;

    assign cfg_pins = '{speed: speed_e'(speed_mode), dsel: div_sel};

    fclk_cfg_latch #(
        .SINGLE_BASE (SINGLE_BASE),
        .RATIO_W     (RATIO_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_in  (cfg_pins),
        .ratio_q (ratio)
    );

    fclk_frac_div #(
        .STEP  (BITS_PER_FRAME),
        .ACC_W (RATIO_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .ratio  (ratio),
        .tick_d (tick_d),
        .tick_q (bit_tick)
    );

    fclk_frame_seq #(
        .BITS_PER_FRAME (BITS_PER_FRAME)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick_d      (tick_d),
        .lrclk       (lrclk),
        .frame_start (frame_start)
    );

    p_frame_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> bit_tick);

    p_lr_moves_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |-> $stable(lrclk));

endmodule

// File: tb/fclk_gen_tb.sv
module fclk_gen_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit    tick;
        bit    frame;
        bit    lr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_mode = 2'b00;
    logic [1:0] div_sel = 2'b00;
    logic       bit_tick;
    logic       frame_start;
    logic       lrclk;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fclk_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .speed_mode  (speed_mode),
        .div_sel     (div_sel),
        .bit_tick    (bit_tick),
        .frame_start (frame_start),
        .lrclk       (lrclk)
    );

    task automatic check(input bit act, input bit exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item per master clock, a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(bit_tick,    e.tick,  {e.tag, " R4 R8 bit_tick"});
                check(frame_start, e.frame, {e.tag, " R5 frame_start"});
                check(lrclk,       e.lr,    {e.tag, " R5 lrclk"});
            end
        end
    end

    // Driver: resets with a configuration, then queues the expected strobes.
    task automatic run_cfg(input logic [1:0] sp, input logic [1:0] ds,
                           input int ratio, input string tag, input bit disturb);
        int n;
        @(negedge clk);
        rst = 1'b1;
        speed_mode = sp;
        div_sel = ds;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(bit_tick,    1'b0, "R7 bit_tick in reset");
            check(frame_start, 1'b0, "R7 frame_start in reset");
            check(lrclk,       1'b0, "R7 lrclk in reset");
        end
        rst = 1'b0;
        n = 0;
        for (int t = 1; t <= 2 * ratio + 8; t++) begin
            exp_t e;
            e.tick  = ((64 * t) / ratio) != ((64 * (t - 1)) / ratio);
            if (e.tick) n++;
            e.frame = e.tick && (((n - 1) % 64) == 0);
            e.lr    = (n > 0) && (((n - 1) % 64) >= 32);
            e.tag   = tag;
            q.push_back(e);
        end
        if (disturb) begin
            repeat (20) @(negedge clk);
            speed_mode = ~sp;
            div_sel    = ~ds;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        run_cfg(2'b00, 2'b00,  256, "R1 single/00", 1'b0);
        run_cfg(2'b00, 2'b01,  384, "R1 single/01", 1'b0);
        run_cfg(2'b00, 2'b10,  512, "R1 single/10", 1'b0);
        run_cfg(2'b00, 2'b11, 1024, "R1 single/11", 1'b0);
        run_cfg(2'b01, 2'b00,  128, "R2 double/00", 1'b0);
        run_cfg(2'b01, 2'b01,  192, "R2 double/01", 1'b0);
        run_cfg(2'b01, 2'b10,  256, "R2 double/10", 1'b0);
        run_cfg(2'b01, 2'b11,  512, "R2 double/11", 1'b0);
        run_cfg(2'b10, 2'b00,   64, "R3 quad/00", 1'b0);
        run_cfg(2'b10, 2'b01,   96, "R3 quad/01", 1'b0);
        run_cfg(2'b10, 2'b10,  128, "R3 quad/10", 1'b0);
        run_cfg(2'b10, 2'b11,  256, "R3 quad/11", 1'b0);
        run_cfg(2'b11, 2'b01,   96, "R3 quad-alt/01", 1'b0);
        // R6: pins flip after release; strobes must keep the captured ratio.
        run_cfg(2'b00, 2'b01,  384, "R6 pins changed", 1'b1);
        run_cfg(2'b10, 2'b00,   64, "R6 pins changed", 1'b1);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule